// File: doc/BRIEF.md
# Byte-Steered Conversion Result Port

This block holds the latest result of a dual-slope style converter and lets a host with an 8-bit bus read it one byte at a time. The result is a 12-bit magnitude plus a sign (polarity) flag and an over-range flag. The converter delivers a new result by raising a one-cycle load strobe. The block stores that result in a register and keeps it until the next strobe.

A host reads the stored value through three active-low selects: a shared port select, a low-byte select and a high-byte select. Direct reads work only while the mode input is low. The low byte carries result bits 7..0. The high byte carries result bits 11..8, then the over-range flag, then the polarity flag, with its top two bits at zero.

Each byte has its own output-enable flag. At the chip level these flags drive the enables of the tri-state pads, so a deselected byte leaves the bus undriven. The block also passes the converter's busy/status line out to the host, one cycle later. The host uses that line to time its reads so that it does not fetch a byte while the register is being reloaded.

The result input is a stream with a valid strobe and no ready. The block accepts a result in any cycle. It applies no back-pressure, and a new strobe always overwrites the stored value.

Top module: `result_byte_port`

## Requirements
- R1: After reset the stored result, polarity, over-range and status output are all zero.
- R2: `lo_oe` is 1 exactly when `mode_sel` is 0, `port_sel_n` is 0 and `lo_sel_n` is 0.
- R3: `hi_oe` is 1 exactly when `mode_sel` is 0, `port_sel_n` is 0 and `hi_sel_n` is 0.
- R4: While `mode_sel` is 1, both `lo_oe` and `hi_oe` are 0, whatever the selects are.
- R5: When only the low byte is enabled, `bus_out` equals stored result bits [7:0].
- R6: When only the high byte is enabled, `bus_out` holds:
  - bits [3:0]: stored result bits [11:8];
  - bit 4: over-range;
  - bit 5: polarity;
  - bits [7:6]: 0.
- R7: When `res_valid` is 1 at a rising clock edge, the result, polarity and over-range inputs are stored at that edge. Without the strobe, the stored values do not change.
- R8: When both bytes are enabled, both output-enable flags are 1 and `bus_out` carries the low byte. `dbg_word` always shows {high byte, low byte} of the stored value.
- R9: When no byte is enabled, `bus_out` is 0.
- R10: `status_out` equals the value `conv_status` had at the previous rising clock edge.
- R11: A select held at its inactive level 1 (the pull-up default of an unconnected pin) never enables a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe: load a new result |
| res_mag | input | 12 | Result magnitude |
| res_pol | input | 1 | Polarity flag of the result |
| res_ovr | input | 1 | Over-range flag of the result |
| conv_status | input | 1 | Busy/status line from the converter |
| mode_sel | input | 1 | 0 = direct byte access enabled |
| port_sel_n | input | 1 | Shared port select, active low |
| lo_sel_n | input | 1 | Low-byte select, active low |
| hi_sel_n | input | 1 | High-byte select, active low |
| bus_out | output | 8 | Byte presented to the host bus |
| lo_oe | output | 1 | Output enable for the low byte |
| hi_oe | output | 1 | Output enable for the high byte |
| status_out | output | 1 | Registered copy of `conv_status` |
| dbg_word | output | 16 | Stored value as {high byte, low byte} |

## Verification
The bench builds the block with its default parameters: a 12-bit result on an 8-bit bus. This leaves a 4-bit field at the bottom of the high byte, so the flags land at bits 4 and 5 and bits 7..6 are padding. With that build, random strobes, mode values and select combinations reach every decode case. Directed cases cover the all-ones result with both flags set and a result held while no strobe arrives.

// File: rtl/rport_pkg.sv
package rport_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_LO   = 2'b01,
    SEL_HI   = 2'b10,
    SEL_BOTH = 2'b11
  } byte_sel_e;
endpackage

// File: rtl/rport_capture.sv
module rport_capture #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] mag_in,
  input  logic             pol_in,
  input  logic             ovr_in,
  input  logic             stat_in,
  output logic [RES_W-1:0] mag_q,
  output logic             pol_q,
  output logic             ovr_q,
  output logic             stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      pol_q  <= 1'b0;
      ovr_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      stat_q <= stat_in;
      if (load) begin
        mag_q <= mag_in;
        pol_q <= pol_in;
        ovr_q <= ovr_in;
      end
    end
  end
endmodule

// File: rtl/rport_decode.sv
module rport_decode
  import rport_pkg::*;
(
  input  logic      mode_sel,
  input  logic      port_sel_n,
  input  logic      lo_sel_n,
  input  logic      hi_sel_n,
  output byte_sel_e sel,
  output logic      lo_oe,
  output logic      hi_oe
);
  logic port_on;

  always_comb begin
    // A select counts as active only at logic 0; the pull-up level 1 is idle.
    port_on = (mode_sel == 1'b0) && (port_sel_n == 1'b0);
    lo_oe   = port_on && (lo_sel_n == 1'b0);
    hi_oe   = port_on && (hi_sel_n == 1'b0);
    sel     = byte_sel_e'({hi_oe, lo_oe});
  end
endmodule

// File: rtl/rport_pack.sv
module rport_pack #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic [RES_W-1:0] mag,
  input  logic             pol,
  input  logic             ovr,
  output logic [BUS_W-1:0] lo_byte,
  output logic [BUS_W-1:0] hi_byte
);
  localparam int HI_W   = RES_W - BUS_W;
  localparam int OVR_AT = HI_W;
  localparam int POL_AT = HI_W + 1;

  assign lo_byte = mag[BUS_W-1:0];

  for (genvar b = 0; b < BUS_W; b++) begin : g_hi
    if (b < HI_W) begin : g_mag
      assign hi_byte[b] = mag[BUS_W+b];
    end else if (b == OVR_AT) begin : g_ovr
      assign hi_byte[b] = ovr;
    end else if (b == POL_AT) begin : g_pol
      assign hi_byte[b] = pol;
    end else begin : g_pad
      assign hi_byte[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rport_mux.sv
module rport_mux
  import rport_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  byte_sel_e        sel,
  input  logic [BUS_W-1:0] lo_byte,
  input  logic [BUS_W-1:0] hi_byte,
  output logic [BUS_W-1:0] bus
);
  always_comb begin
    unique case (sel)
      SEL_LO, SEL_BOTH: bus = lo_byte;
      SEL_HI:           bus = hi_byte;
      default:          bus = '0;
    endcase
  end
endmodule

// File: rtl/result_byte_port.sv
module result_byte_port #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_mag,
  input  logic               res_pol,
  input  logic               res_ovr,
  input  logic               conv_status,
  input  logic               mode_sel,
  input  logic               port_sel_n,
  input  logic               lo_sel_n,
  input  logic               hi_sel_n,
  output logic [BUS_W-1:0]   bus_out,
  output logic               lo_oe,
  output logic               hi_oe,
  output logic               status_out,
  output logic [2*BUS_W-1:0] dbg_word
);
  import rport_pkg::*;

  localparam int HI_W = RES_W - BUS_W;

  initial begin
    if (HI_W < 1 || HI_W + 2 > BUS_W)
      $display("result_byte_port: RES_W/BUS_W combination unsupported");
  end

  logic [RES_W-1:0] mag_q;
  logic             pol_q, ovr_q;
  logic [BUS_W-1:0] lo_byte, hi_byte;
  byte_sel_e        sel;

  rport_capture #(.RES_W(RES_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(res_valid),
    .mag_in(res_mag), .pol_in(res_pol), .ovr_in(res_ovr), .stat_in(conv_status),
    .mag_q(mag_q), .pol_q(pol_q), .ovr_q(ovr_q), .stat_q(status_out)
  );

  rport_decode u_dec (
    .mode_sel(mode_sel), .port_sel_n(port_sel_n),
    .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n),
    .sel(sel), .lo_oe(lo_oe), .hi_oe(hi_oe)
  );

  rport_pack #(.RES_W(RES_W), .BUS_W(BUS_W)) u_pack (
    .mag(mag_q), .pol(pol_q), .ovr(ovr_q),
    .lo_byte(lo_byte), .hi_byte(hi_byte)
  );

  rport_mux #(.BUS_W(BUS_W)) u_mux (
    .sel(sel), .lo_byte(lo_byte), .hi_byte(hi_byte), .bus(bus_out)
  );

  assign dbg_word = {hi_byte, lo_byte};
endmodule

// File: rtl/result_byte_port_chk.sv
module result_byte_port_chk #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               res_valid,
  input logic               conv_status,
  input logic               mode_sel,
  input logic               port_sel_n,
  input logic               lo_sel_n,
  input logic               hi_sel_n,
  input logic [BUS_W-1:0]   bus_out,
  input logic               lo_oe,
  input logic               hi_oe,
  input logic               status_out,
  input logic [2*BUS_W-1:0] dbg_word
);
  AST_LO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_oe |-> (!mode_sel && !port_sel_n && !lo_sel_n)); // R2
  AST_HI_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe |-> (!mode_sel && !port_sel_n && !hi_sel_n)); // R3
  AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |-> (!lo_oe && !hi_oe)); // R4
  AST_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_oe && !lo_oe) |-> (bus_out[BUS_W-1:RES_W-BUS_W+2] == '0)); // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(dbg_word)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_oe && !hi_oe) |-> (bus_out == '0)); // R9
  AST_STATUS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_out == $past(conv_status))); // R10
  AST_PULLUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel_n |-> (!lo_oe && !hi_oe)); // R11
endmodule

bind result_byte_port result_byte_port_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .conv_status(conv_status),
  .mode_sel(mode_sel), .port_sel_n(port_sel_n), .lo_sel_n(lo_sel_n),
  .hi_sel_n(hi_sel_n), .bus_out(bus_out), .lo_oe(lo_oe), .hi_oe(hi_oe),
  .status_out(status_out), .dbg_word(dbg_word)
);

// File: tb/result_byte_port_test.sv
`timescale 1ns/1ps
module result_byte_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [11:0] res_mag = '0;
  logic        res_pol = 1'b0, res_ovr = 1'b0, conv_status = 1'b0;
  logic        mode_sel = 1'b1, port_sel_n = 1'b1, lo_sel_n = 1'b1, hi_sel_n = 1'b1;
  logic [7:0]  bus_out;
  logic        lo_oe, hi_oe, status_out;
  logic [15:0] dbg_word;

  int total = 0;
  int bad = 0;

  logic [11:0] m_mag = '0;
  logic        m_pol = 1'b0, m_ovr = 1'b0, m_stat = 1'b0;

  always #5 clk = ~clk;

  result_byte_port uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_mag(res_mag),
    .res_pol(res_pol), .res_ovr(res_ovr), .conv_status(conv_status),
    .mode_sel(mode_sel), .port_sel_n(port_sel_n), .lo_sel_n(lo_sel_n),
    .hi_sel_n(hi_sel_n), .bus_out(bus_out), .lo_oe(lo_oe), .hi_oe(hi_oe),
    .status_out(status_out), .dbg_word(dbg_word)
  );

  function automatic logic [7:0] f_hi(logic [11:0] m, logic p, logic o);
    return {2'b00, p, o, m[11:8]};
  endfunction

  function automatic logic [7:0] f_bus(logic lo, logic hi, logic [11:0] m, logic p, logic o);
    if (lo) return m[7:0];
    if (hi) return f_hi(m, p, o);
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let the rising edge pass, then compare.
  task automatic step(logic v, logic [11:0] m, logic p, logic o, logic st,
                      logic md, logic cs, logic lo, logic hi);
    logic elo, ehi;
    @(negedge clk);
    res_valid = v; res_mag = m; res_pol = p; res_ovr = o; conv_status = st;
    mode_sel = md; port_sel_n = cs; lo_sel_n = lo; hi_sel_n = hi;
    @(posedge clk);
    if (v) begin m_mag = m; m_pol = p; m_ovr = o; end
    m_stat = st;
    #2;
    elo = !md && !cs && !lo;
    ehi = !md && !cs && !hi;
    chk("R2 lo_oe", 32'(lo_oe), 32'(elo));
    chk("R3 hi_oe", 32'(hi_oe), 32'(ehi));
    chk("R5/R6/R9 bus", 32'(bus_out), 32'(f_bus(elo, ehi, m_mag, m_pol, m_ovr)));
    chk("R7/R8 dbg_word", 32'(dbg_word), 32'({f_hi(m_mag, m_pol, m_ovr), m_mag[7:0]}));
    chk("R10 status_out", 32'(status_out), 32'(m_stat));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 dbg_word", 32'(dbg_word), 32'h0);
    chk("R1 status_out", 32'(status_out), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R6: all-ones result with both flags, high byte only
    step(1, 12'hFFF, 1, 1, 0, 0, 0, 1, 0);
    chk("R6 hi layout", 32'(bus_out), 32'h3F);
    // R5: low byte only
    step(0, 12'h000, 0, 0, 1, 0, 0, 0, 1);
    chk("R5 lo byte", 32'(bus_out), 32'hFF);
    // R7: hold without strobe although inputs change
    step(0, 12'h123, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 hold", 32'(dbg_word), 32'h3FFF);
    // R8: both bytes enabled
    step(1, 12'hA5C, 1, 0, 0, 0, 0, 0, 0);
    chk("R8 both oe", 32'({hi_oe, lo_oe}), 32'h3);
    chk("R8 bus low", 32'(bus_out), 32'h5C);
    // R4: mode high blocks all
    step(0, 12'h0, 0, 0, 1, 1, 0, 0, 0);
    chk("R4 mode block", 32'({hi_oe, lo_oe, bus_out}), 32'h0);
    // R11: pull-up idle levels on all selects
    step(0, 12'h0, 0, 0, 0, 0, 1, 1, 1);
    chk("R11 idle", 32'({hi_oe, lo_oe}), 32'h0);
    // R9: port selected, no byte
    step(0, 12'h0, 0, 0, 0, 0, 0, 1, 1);
    chk("R9 zero bus", 32'(bus_out), 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], 12'($urandom), r[1], r[2], r[3], (r[7:4] == 4'h0),
           r[8] & r[9], r[10], r[11]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule